// File: doc/BRIEF.md
# Tick Counter with Compare Match

This block keeps a free-running tick count and a compare value, and raises a match pulse when the count reaches the compare value. Both registers are 64 bits wide at the bus, but only the low 63 bits hold data. Bit 63 of any write is stripped off and kept as a single control flag. That flag appears again as bit 63 of every count read, and while it is set no match can be armed.

The `KIND` parameter picks the instance flavour. The main tick instance treats the flag as a read-restriction marker and routes its match to the tick-match line. The system and hypervisor instances treat the flag as an interrupt disable and route their match to the system-tick-match line. Each match also drives a wake line to a halted core.

A compare value of zero never arms the timer. A compare value that the counter has already reached or passed fires on the very next tick, so it is not lost.

Top module: `tick_timer`

## Requirements
- R1: After reset the count is zero, the control flag is set (a read returns 64'h8000_0000_0000_0000), and no match or wake output is high.
- R2: A count write loads `wdata_i[62:0]` as the new count and `wdata_i[63]` as the control flag. From the next cycle `cnt_rdata_o` equals `{flag, count}` and `ctrl_flag_o` equals the flag.
- R3: In each cycle with `tick_en_i` high and no count write, the 63-bit count advances by one and wraps from 2^63-1 to 0 without changing bit 63. With `tick_en_i` low and no count write, the count holds.
- R4: A compare write takes `wdata_i[62:0]` as the match value and `wdata_i[63]` as the new flag. It arms a match only when the value is nonzero and bit 63 is zero.
- R5: An armed match fires on the tick edge at which the count advances to the match value. The hit output is high for exactly the one cycle after that edge, and the match is then disarmed, so it fires once per arming.
- R6: If the match value is at or below the count held after the compare-write edge, the match fires on the next tick edge that has no write.
- R7: A compare value of zero never produces a match.
- R8: Setting the flag, through either write, cancels any armed match. No hit follows while the flag is set.
- R9: With `KIND` = tick, matches appear on `tick_hit_o` and `stick_hit_o` stays low. With the system or hypervisor kind, matches appear on `stick_hit_o` only. `wake_o` pulses with either hit.
- R10: A count write takes priority over the increment. A match is never taken on an edge that carries a write. If both writes occur in one cycle, the common data word loads both registers and the match fires on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Count enable for this cycle |
| cnt_we_i | input | 1 | Count register write strobe |
| cmp_we_i | input | 1 | Compare register write strobe |
| wdata_i | input | 64 | Write data shared by both registers |
| cnt_rdata_o | output | 64 | Count with the control flag merged into bit 63 |
| ctrl_flag_o | output | 1 | Control flag |
| tick_hit_o | output | 1 | Match pulse for the main tick instance |
| stick_hit_o | output | 1 | Match pulse for the system and hypervisor instances |
| wake_o | output | 1 | Core wake pulse on any match |

## Verification
A write or a tick shows on `cnt_rdata_o` one cycle after the edge that samples it, and a match pulse is due in the cycle right after the tick edge that reaches the compare value. The bench drives inputs on the falling edge and runs its reference model at each rising edge. It compares every output one time unit after that rising edge, so each expected value lines up with the edge that produced it. Directed sequences cover wrap, late compare, zero compare, flag cancellation and simultaneous writes. A seeded random phase then mixes writes near the running count to force frequent matches.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic [1:0] {
    KIND_TICK   = 2'd0,
    KIND_STICK  = 2'd1,
    KIND_HSTICK = 2'd2
  } inst_kind_e;

  localparam int unsigned TICK_W = 64;
endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned CW = 63
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_en_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q;

  always_comb begin
    if (load_i)         cnt_nxt_o = load_val_i;
    else if (tick_en_i) cnt_nxt_o = cnt_q + ONE;
    else                cnt_nxt_o = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tick_compare.sv
module tick_compare #(
  parameter int unsigned CW = 63
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_en_i,
  input  logic          cnt_we_i,
  input  logic          cmp_we_i,
  input  logic [CW:0]   wdata_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cnt_nxt_i,
  output logic          hit_o
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cmp_q;
  logic          armed_q, late_q, hit_q;
  logic          fire;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = cnt_i + ONE;
  // match only on a clean tick edge; a late arming fires on the first such edge
  assign fire = armed_q && tick_en_i && !cnt_we_i && !cmp_we_i &&
                (late_q || (cnt_inc == cmp_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q   <= '0;
      armed_q <= 1'b0;
      late_q  <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      hit_q <= fire;
      if (cmp_we_i) begin
        cmp_q   <= wdata_i[CW-1:0];
        armed_q <= (wdata_i[CW-1:0] != '0) && !wdata_i[CW];
        late_q  <= (wdata_i[CW-1:0] <= cnt_nxt_i);
      end else if (cnt_we_i && wdata_i[CW]) begin
        armed_q <= 1'b0;
      end else if (fire) begin
        armed_q <= 1'b0;
        late_q  <= 1'b0;
      end
    end
  end

  assign hit_o = hit_q;
endmodule

// File: rtl/tick_route.sv
module tick_route
  import tick_pkg::*;
#(
  parameter inst_kind_e KIND = KIND_TICK
) (
  input  logic hit_i,
  output logic tick_hit_o,
  output logic stick_hit_o,
  output logic wake_o
);
  generate
    if (KIND == KIND_TICK) begin : g_main
      assign tick_hit_o  = hit_i;
      assign stick_hit_o = 1'b0;
    end else begin : g_sys
      assign tick_hit_o  = 1'b0;
      assign stick_hit_o = hit_i;
    end
  endgenerate

  assign wake_o = hit_i;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int unsigned W    = TICK_W,
  parameter inst_kind_e  KIND = KIND_TICK
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_en_i,
  input  logic         cnt_we_i,
  input  logic         cmp_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_rdata_o,
  output logic         ctrl_flag_o,
  output logic         tick_hit_o,
  output logic         stick_hit_o,
  output logic         wake_o
);
  localparam int unsigned CW = W - 1;

  logic [CW-1:0] cnt, cnt_nxt;
  logic          flag_q;
  logic          hit;

  // bit W-1 is a control flag; either write updates it from the shared bus
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   flag_q <= 1'b1;
    else if (cnt_we_i || cmp_we_i) flag_q <= wdata_i[CW];
  end

  tick_counter #(.CW(CW)) i_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_en_i  (tick_en_i),
    .load_i     (cnt_we_i),
    .load_val_i (wdata_i[CW-1:0]),
    .cnt_o      (cnt),
    .cnt_nxt_o  (cnt_nxt)
  );

  tick_compare #(.CW(CW)) i_compare (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_en_i (tick_en_i),
    .cnt_we_i  (cnt_we_i),
    .cmp_we_i  (cmp_we_i),
    .wdata_i   (wdata_i),
    .cnt_i     (cnt),
    .cnt_nxt_i (cnt_nxt),
    .hit_o     (hit)
  );

  tick_route #(.KIND(KIND)) i_route (
    .hit_i       (hit),
    .tick_hit_o  (tick_hit_o),
    .stick_hit_o (stick_hit_o),
    .wake_o      (wake_o)
  );

  assign cnt_rdata_o = {flag_q, cnt};
  assign ctrl_flag_o = flag_q;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned W = 64
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_en_i,
  input logic         cnt_we_i,
  input logic         cmp_we_i,
  input logic [W-1:0] wdata_i,
  input logic [W-1:0] cnt_rdata_o,
  input logic         ctrl_flag_o,
  input logic         tick_hit_o,
  input logic         stick_hit_o,
  input logic         wake_o
);
  localparam logic [W-2:0] ONE = {{(W-2){1'b0}}, 1'b1};

  // R2
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_rdata_o == $past(wdata_i));

  // R3
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_en_i && !cnt_we_i |=> cnt_rdata_o[W-2:0] == $past(cnt_rdata_o[W-2:0]) + ONE);

  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_en_i && !cnt_we_i |=> $stable(cnt_rdata_o[W-2:0]));

  // R5
  hit_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  // R7
  zero_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_we_i && (wdata_i[W-2:0] == '0) |=> !wake_o ##1 !wake_o);

  // R8
  flag_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_flag_o |=> !wake_o);

  // R9
  route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tick_hit_o, stick_hit_o}));
endmodule

bind tick_timer tick_timer_chk #(.W(W)) i_tick_timer_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_en_i   (tick_en_i),
  .cnt_we_i    (cnt_we_i),
  .cmp_we_i    (cmp_we_i),
  .wdata_i     (wdata_i),
  .cnt_rdata_o (cnt_rdata_o),
  .ctrl_flag_o (ctrl_flag_o),
  .tick_hit_o  (tick_hit_o),
  .stick_hit_o (stick_hit_o),
  .wake_o      (wake_o)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;
  import tick_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, cw = 1'b0, mw = 1'b0;
  logic [W-1:0] wd = '0;

  logic [W-1:0] rd_a, rd_b;
  logic flag_a, flag_b, th_a, sh_a, wk_a, th_b, sh_b, wk_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [62:0] m_cnt, m_cmp;
  bit m_flag, m_armed, m_late, m_hit;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer #(.W(W), .KIND(KIND_TICK)) i_tick_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(en), .cnt_we_i(cw), .cmp_we_i(mw),
    .wdata_i(wd), .cnt_rdata_o(rd_a), .ctrl_flag_o(flag_a),
    .tick_hit_o(th_a), .stick_hit_o(sh_a), .wake_o(wk_a)
  );

  tick_timer #(.W(W), .KIND(KIND_HSTICK)) i_tick_timer_sys (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(en), .cnt_we_i(cw), .cmp_we_i(mw),
    .wdata_i(wd), .cnt_rdata_o(rd_b), .ctrl_flag_o(flag_b),
    .tick_hit_o(th_b), .stick_hit_o(sh_b), .wake_o(wk_b)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = '0; m_cmp = '0; m_flag = 1'b1; m_armed = 1'b0; m_late = 1'b0; m_hit = 1'b0;
  endtask

  // reference behaviour taken from the requirement list
  task automatic model_edge(input bit e, input bit c, input bit m, input logic [63:0] d);
    logic [62:0] nxt;
    logic [62:0] inc;
    bit fire;
    inc  = m_cnt + 63'd1;
    fire = m_armed && e && !c && !m && (m_late || inc == m_cmp);
    nxt  = c ? d[62:0] : (e ? inc : m_cnt);
    if (m) begin
      m_cmp   = d[62:0];
      m_armed = (d[62:0] != 63'd0) && !d[63];
      m_late  = d[62:0] <= nxt;
    end else if (c && d[63]) begin
      m_armed = 1'b0;
    end else if (fire) begin
      m_armed = 1'b0;
      m_late  = 1'b0;
    end
    if (c || m) m_flag = d[63];
    m_cnt = nxt;
    m_hit = fire;
  endtask

  task automatic check_all(input string tag);
    chk(rd_a == {m_flag, m_cnt}, {tag, " read"}, rd_a, {m_flag, m_cnt});
    chk(flag_a == m_flag, {tag, " flag"}, 64'(flag_a), 64'(m_flag));
    chk(th_a == m_hit && wk_a == m_hit, {tag, " hit"}, 64'({th_a, wk_a}), 64'({m_hit, m_hit}));
    // R9: system instance routes to the other line
    chk(sh_b == m_hit && !th_b && !sh_a && wk_b == m_hit, "R9 route",
        64'({th_b, sh_b, wk_b, sh_a}), 64'({1'b0, m_hit, m_hit, 1'b0}));
  endtask

  task automatic step(input bit e, input bit c, input bit m, input logic [63:0] d, input string tag);
    @(negedge clk);
    en = e; cw = c; mw = m; wd = d;
    @(posedge clk);
    model_edge(e, c, m, d);
    #1;
    check_all(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, '0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    model_reset();
    #(CLK_PERIOD * 2 + 2);
    // R1 reset state
    chk(rd_a == 64'h8000_0000_0000_0000, "R1 reset read", rd_a, 64'h8000_0000_0000_0000);
    chk(!th_a && !wk_a && !sh_b && flag_a, "R1 reset outputs", 64'({th_a, wk_a, sh_b, flag_a}), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 load with flag clear
    step(1'b0, 1'b1, 1'b0, 64'h0000_0000_0000_0010, "R2");
    chk(rd_a == 64'h10, "R2 direct", rd_a, 64'h10);
    // R3 count and hold
    idle(3, "R3");
    chk(rd_a == 64'h13, "R3 direct", rd_a, 64'h13);
    step(1'b0, 1'b0, 1'b0, '0, "R3 hold");
    chk(rd_a == 64'h13, "R3 hold direct", rd_a, 64'h13);

    // R5 normal match: compare 0x18, hit once
    step(1'b1, 1'b0, 1'b1, 64'h18, "R4");
    idle(8, "R5");
    idle(4, "R5 once");

    // R6 late compare
    step(1'b1, 1'b0, 1'b1, 64'h5, "R6");
    step(1'b1, 1'b0, 1'b0, '0, "R6");
    chk(wk_a == 1'b1, "R6 direct late fire", 64'(wk_a), 64'd1);
    idle(2, "R6");

    // R7 zero compare
    step(1'b1, 1'b0, 1'b1, 64'h0, "R7");
    idle(5, "R7");

    // R4 compare write with bit 63 set: flag shown, not armed
    step(1'b1, 1'b0, 1'b1, {1'b1, 63'(m_cnt + 63'd3)}, "R4 flag");
    chk(flag_a == 1'b1, "R4 direct flag", 64'(flag_a), 64'd1);
    idle(6, "R4");

    // R8 arm, then cancel via count write with bit 63
    step(1'b1, 1'b1, 1'b0, 64'h100, "R2");
    step(1'b1, 1'b0, 1'b1, 64'h108, "R8");
    step(1'b1, 1'b1, 1'b0, {1'b1, 63'h102}, "R8");
    step(1'b1, 1'b1, 1'b0, 64'h103, "R8");
    idle(12, "R8");

    // R3 wrap
    step(1'b1, 1'b1, 1'b0, 64'h7FFF_FFFF_FFFF_FFFE, "R3 wrap");
    idle(3, "R3 wrap");
    chk(rd_a == 64'h1, "R3 wrap direct", rd_a, 64'h1);

    // R10 simultaneous writes, and count write overriding tick
    step(1'b1, 1'b1, 1'b1, 64'h40, "R10");
    idle(2, "R10");
    step(1'b1, 1'b0, 1'b1, 64'h48, "R10");
    step(1'b1, 1'b1, 1'b0, 64'h47, "R10");
    step(1'b1, 1'b0, 1'b0, '0, "R10");
    chk(wk_a == 1'b1, "R10 direct match after load", 64'(wk_a), 64'd1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      bit e, c, m;
      logic [63:0] d;
      r = $urandom % 100;
      e = (r < 85);
      r = $urandom % 100;
      c = (r < 3);
      m = (r >= 3 && r < 9) || (r == 99);
      d[62:0] = m_cnt + 63'($urandom % 24) - 63'd6;
      if ($urandom % 20 == 0) d[62:0] = '0;
      if (c && ($urandom % 4 == 0)) d[62:0] = {$urandom, $urandom};
      d[63] = ($urandom % 8 == 0);
      step(e, c, m, d, "R5 random");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule